// File: doc/BRIEF.md
# Bus Width Conversion Sequencer

This block sits beside a bus master whose data path is 32, 64 or 128 bits wide, fixed by a parameter. When the address phase of a request is acknowledged, the slave reports its own data width in the same cycle. If that slave is narrower than the master, one master request must be split into several narrower data beats. The block works out how many beats are needed from the master width, the slave width and the transfer-size code. It then steps a beat address through the request, one data acknowledge at a time, and pulses a done flag when the last beat has moved.

For writes it moves the slave-width slice of the master write word that belongs to the current beat onto the low byte lanes. For reads it places the low lanes of each returned beat into the matching slice of a master-width read buffer. Single transfers move one master word. Line transfers move a line of 4, 8 or 16 32-bit words. Reads and writes follow the same sequence.

Top module: `bus_width_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `conv_active` are 0 and `rd_buf` is all zeros.
- R2: `ack_ssize` is sampled only in a cycle where `addr_ack` is high while the block is idle. After that edge `busy` is 1. The effective slave size is the smaller of `ack_ssize` and the master size code (00 = 32, 01 = 64, 10 = 128, 11 = wider than any master). `conv_active` is 1 while busy exactly when the effective size is below the master size.
- R3: A single transfer (`req_tsize` 0000) takes master width / effective slave width beats, starting at the request address aligned down to the master width. A 64-bit master with a 32-bit slave therefore takes two beats, which is one extra cycle.
- R4: Line codes 0001, 0010 and 0011 move 16, 32 and 64 bytes. They take line bytes / effective slave bytes beats, starting at the request address aligned down to the line size.
- R5: Any other `req_tsize` code is handled exactly like a single transfer.
- R6: Each data acknowledge while busy advances `beat_addr` by the effective slave width in bytes. Without a data acknowledge, `beat_addr` holds.
- R7: While busy, `wr_lanes` carries on its low slave-width bits the slice of `m_wdata` that starts at byte offset (`beat_addr` mod master bytes). All bits above the slave width are zero.
- R8: On each data acknowledge of a read, the low slave-width bits of `rd_lanes` are written into `rd_buf` at byte offset (`beat_addr` mod master bytes). All other bits of `rd_buf`, and all of `rd_buf` during writes and idle cycles, keep their value.
- R9: `done` is high for exactly one cycle, directly after the edge that takes the final data acknowledge. `busy` falls at that same edge.
- R10: `data_ack` while idle has no effect. `addr_ack` while busy is ignored and does not change the beat count or the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_ack | input | 1 | Address acknowledge; starts a sequence when idle |
| ack_ssize | input | 2 | Slave size code returned with `addr_ack` |
| req_addr | input | AW | Request byte address |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_tsize | input | 4 | Transfer-size code |
| data_ack | input | 1 | Data acknowledge, one per beat |
| m_wdata | input | MW | Master write word |
| rd_lanes | input | MW | Read data lanes from the slave |
| busy | output | 1 | Sequence in progress |
| conv_active | output | 1 | Current sequence is a width conversion |
| beat_addr | output | AW | Byte address of the current beat |
| wr_lanes | output | MW | Write data steered to the low lanes |
| rd_buf | output | MW | Assembled master read word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a second `addr_ack` arriving in the middle of a long conversion. It must be ignored, but it would silently change the beat count or the base address if it were not. The stimulus drives a 16-beat line read with wait states between data acknowledges, and raises `addr_ack` with a different size and address during one of those waits. The scoreboard then requires the original address sequence and beat count. Slave codes that are wider than the master, and transfer codes outside the line set, are driven on purpose so that the clamping and fallback paths are exercised.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic [1:0] {
    SZ_W32  = 2'b00,
    SZ_W64  = 2'b01,
    SZ_W128 = 2'b10,
    SZ_WIDE = 2'b11
  } size_code_e;

  localparam int MAX_BEATS = 16;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  // slave code clamped to the master width
  function automatic logic [1:0] eff_size(input logic [1:0] ss, input logic [1:0] ms);
    return (ss > ms) ? ms : ss;
  endfunction

  function automatic logic is_line(input logic [3:0] t);
    return (t == 4'd1) || (t == 4'd2) || (t == 4'd3);
  endfunction

  function automatic logic [CNT_W-1:0] beat_total(input logic [3:0] t,
                                                  input logic [1:0] eff,
                                                  input logic [1:0] ms);
    int n;
    if (is_line(t)) n = (4 << (int'(t[1:0]) - 1)) >> eff;
    else            n = 1 << (ms - eff);
    return CNT_W'(n);
  endfunction

endpackage

// File: rtl/bwc_size_capture.sv
module bwc_size_capture
  import bwc_pkg::*;
#(
  parameter int MSZ = 1,
  parameter int AW  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       ssize,
  input  logic [AW-1:0]    addr,
  input  logic             rnw,
  input  logic [3:0]       tsize,
  output logic [AW-1:0]    base_nxt,
  output logic [1:0]       eff_q,
  output logic             rnw_q,
  output logic [CNT_W-1:0] total_q
);
  localparam int MBYTES = (32 << MSZ) / 8;
  localparam logic [1:0] MS = 2'(MSZ);

  logic [1:0]    eff_nxt;
  logic [AW-1:0] amask;

  always_comb begin
    int lb;
    eff_nxt = eff_size(ssize, MS);
    lb      = 16 << (int'(tsize[1:0]) - 1);
    if (is_line(tsize)) amask = ~(AW'(lb) - AW'(1));
    else                amask = ~AW'(MBYTES - 1);
    base_nxt = addr & amask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_q   <= MS;
      rnw_q   <= 1'b0;
      total_q <= '0;
    end else if (start) begin
      eff_q   <= eff_nxt;
      rnw_q   <= rnw;
      total_q <= beat_total(tsize, eff_nxt, MS);
    end
  end
endmodule

// File: rtl/bwc_beat_counter.sv
module bwc_beat_counter
  import bwc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    base_nxt,
  input  logic             data_ack,
  input  logic [1:0]       eff_q,
  input  logic [CNT_W-1:0] total_q,
  output logic             busy,
  output logic [AW-1:0]    beat_addr,
  output logic             done,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign fire = busy && data_ack;
  assign last = (cnt_q + CNT_W'(1)) == total_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt_q     <= '0;
      beat_addr <= '0;
      done      <= 1'b0;
    end else begin
      done <= fire && last;
      if (start) begin
        busy      <= 1'b1;
        cnt_q     <= '0;
        beat_addr <= base_nxt;
      end else if (fire) begin
        beat_addr <= beat_addr + (AW'(4) << eff_q);
        cnt_q     <= cnt_q + CNT_W'(1);
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bwc_lane_steer.sv
module bwc_lane_steer #(
  parameter int MSZ = 1,
  parameter int AW  = 32,
  parameter int MW  = 32 << MSZ
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] beat_addr,
  input  logic [1:0]    eff_q,
  input  logic          rnw_q,
  input  logic          fire,
  input  logic [MW-1:0] m_wdata,
  input  logic [MW-1:0] rd_lanes,
  output logic [MW-1:0] wr_lanes,
  output logic [MW-1:0] rd_buf
);
  localparam int MBYTES = MW / 8;
  localparam int OFFW   = $clog2(MBYTES);

  generate
    if (MSZ == 0) begin : g_narrow
      // 32-bit master: no slave can be narrower
      assign wr_lanes = m_wdata;
      always_ff @(posedge clk) begin
        if (rst)                rd_buf <= '0;
        else if (fire && rnw_q) rd_buf <= rd_lanes;
      end
    end else begin : g_conv
      logic [MW-1:0] mask;
      int            sh;

      always_comb begin
        sh       = int'(beat_addr[OFFW-1:0]) * 8;
        mask     = {MW{1'b1}} >> (MW - (32 << eff_q));
        wr_lanes = (m_wdata >> sh) & mask;
      end

      always_ff @(posedge clk) begin
        if (rst)
          rd_buf <= '0;
        else if (fire && rnw_q)
          rd_buf <= (rd_buf & ~(mask << sh)) | ((rd_lanes & mask) << sh);
      end
    end
  endgenerate
endmodule

// File: rtl/bus_width_seq.sv
module bus_width_seq
  import bwc_pkg::*;
#(
  parameter int MSZ = 1,
  parameter int AW  = 32,
  parameter int MW  = 32 << MSZ
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_ack,
  input  logic [1:0]    ack_ssize,
  input  logic [AW-1:0] req_addr,
  input  logic          req_rnw,
  input  logic [3:0]    req_tsize,
  input  logic          data_ack,
  input  logic [MW-1:0] m_wdata,
  input  logic [MW-1:0] rd_lanes,
  output logic          busy,
  output logic          conv_active,
  output logic [AW-1:0] beat_addr,
  output logic [MW-1:0] wr_lanes,
  output logic [MW-1:0] rd_buf,
  output logic          done
);
  logic             start;
  logic             fire;
  logic [AW-1:0]    base_nxt;
  logic [1:0]       eff_q;
  logic             rnw_q;
  logic [CNT_W-1:0] total_q;

  assign start       = addr_ack && !busy;
  assign conv_active = busy && (eff_q != 2'(MSZ));

  bwc_size_capture #(.MSZ(MSZ), .AW(AW)) u_cap (
    .clk(clk), .rst(rst), .start(start), .ssize(ack_ssize), .addr(req_addr),
    .rnw(req_rnw), .tsize(req_tsize), .base_nxt(base_nxt), .eff_q(eff_q),
    .rnw_q(rnw_q), .total_q(total_q)
  );

  bwc_beat_counter #(.AW(AW)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .base_nxt(base_nxt),
    .data_ack(data_ack), .eff_q(eff_q), .total_q(total_q), .busy(busy),
    .beat_addr(beat_addr), .done(done), .fire(fire)
  );

  bwc_lane_steer #(.MSZ(MSZ), .AW(AW), .MW(MW)) u_lane (
    .clk(clk), .rst(rst), .beat_addr(beat_addr), .eff_q(eff_q),
    .rnw_q(rnw_q), .fire(fire), .m_wdata(m_wdata), .rd_lanes(rd_lanes),
    .wr_lanes(wr_lanes), .rd_buf(rd_buf)
  );
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
  parameter int AW = 32,
  parameter int MW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          addr_ack,
  input logic          data_ack,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] beat_addr,
  input logic [MW-1:0] wr_lanes,
  input logic [MW-1:0] rd_buf,
  input logic [1:0]    eff,
  input logic          rnw
);
  // R2: an address acknowledge while idle starts a sequence
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && addr_ack) |=> busy);

  // R6: each acknowledged beat moves the address by the slave width
  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && data_ack) |=> (!busy || beat_addr == $past(beat_addr) + (AW'(4) << eff)));

  // R10: no acknowledge while busy leaves the sequence untouched
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !data_ack) |=> (busy && $stable(beat_addr)));

  // R7: lanes above the slave width stay zero
  p_wr_upper_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((wr_lanes >> (32 << eff)) == '0));

  // R8: read buffer changes only on an acknowledged read beat
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy && data_ack && rnw) |=> $stable(rd_buf));

  // R9: completion pulse lasts one cycle and leaves the block idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: stray data acknowledge while idle does nothing
  p_idle_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && data_ack && !addr_ack) |=> (!busy && !done));
endmodule

bind bus_width_seq bwc_checker #(.AW(AW), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .addr_ack(addr_ack), .data_ack(data_ack),
  .busy(busy), .done(done), .beat_addr(beat_addr), .wr_lanes(wr_lanes),
  .rd_buf(rd_buf), .eff(eff_q), .rnw(rnw_q)
);

// File: tb/bus_width_seq_tb.sv
`timescale 1ns/1ps
module bus_width_seq_tb;
  localparam int MSZ = 1;
  localparam int AW  = 32;
  localparam int MW  = 32 << MSZ;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          addr_ack = 1'b0;
  logic [1:0]    ack_ssize = '0;
  logic [AW-1:0] req_addr = '0;
  logic          req_rnw = 1'b0;
  logic [3:0]    req_tsize = '0;
  logic          data_ack = 1'b0;
  logic [MW-1:0] m_wdata = '0;
  logic [MW-1:0] rd_lanes = '0;
  logic          busy, conv_active, done;
  logic [AW-1:0] beat_addr;
  logic [MW-1:0] wr_lanes, rd_buf;

  always #2.5 clk = ~clk;

  bus_width_seq #(.MSZ(MSZ), .AW(AW), .MW(MW)) u_dut (
    .clk(clk), .rst(rst), .addr_ack(addr_ack), .ack_ssize(ack_ssize),
    .req_addr(req_addr), .req_rnw(req_rnw), .req_tsize(req_tsize),
    .data_ack(data_ack), .m_wdata(m_wdata), .rd_lanes(rd_lanes),
    .busy(busy), .conv_active(conv_active), .beat_addr(beat_addr),
    .wr_lanes(wr_lanes), .rd_buf(rd_buf), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int popped = 0;

  typedef struct {
    logic [AW-1:0] addr;
    logic [MW-1:0] wr;
    logic          rnw;
  } beat_t;
  beat_t exp_q[$];
  logic [MW-1:0] model_buf = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compares every acknowledged beat against the scoreboard
  always @(negedge clk) begin
    #1;
    if (!rst && busy && data_ack) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3", "unexpected beat", 128'(beat_addr), 0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        popped++;
        chk(beat_addr == e.addr, "R6", "beat address", 128'(beat_addr), 128'(e.addr));
        if (!e.rnw)
          chk(wr_lanes == e.wr, "R7", "write lanes", 128'(wr_lanes), 128'(e.wr));
      end
    end
  end

  task automatic xfer(input logic rnw, input logic [AW-1:0] addr, input logic [3:0] tsize,
                      input logic [1:0] ss, input int gap, input bit poke,
                      input logic [MW-1:0] wd, input string req);
    int eff, sb, n, lb, off;
    bit line;
    logic [AW-1:0]  base;
    logic [MW-1:0]  mask;
    logic [MW-1:0]  pat;
    eff  = (int'(ss) > MSZ) ? MSZ : int'(ss);
    sb   = 4 << eff;
    line = (tsize >= 4'd1) && (tsize <= 4'd3);
    n    = line ? ((4 << (int'(tsize) - 1)) >> eff) : (1 << (MSZ - eff));
    lb   = line ? (16 << (int'(tsize) - 1)) : (MW / 8);
    base = addr & ~AW'(lb - 1);
    mask = MW'((128'd1 << (8 * sb)) - 1);
    for (int i = 0; i < n; i++) begin
      beat_t b;
      b.addr = base + AW'(i * sb);
      off    = int'(b.addr) % (MW / 8);
      b.wr   = (wd >> (8 * off)) & mask;
      b.rnw  = rnw;
      exp_q.push_back(b);
    end
    popped = 0;
    @(negedge clk);
    addr_ack = 1'b1; ack_ssize = ss; req_addr = addr; req_rnw = rnw;
    req_tsize = tsize; m_wdata = wd;
    @(negedge clk);
    addr_ack = 1'b0;
    chk(busy == 1'b1, "R2", "busy after addr ack", 128'(busy), 1);
    chk(conv_active == (eff < MSZ), "R2", "conv_active", 128'(conv_active), 128'(eff < MSZ));
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        if (poke && i == 1 && g == 0) begin
          addr_ack = 1'b1; ack_ssize = 2'b10; req_tsize = 4'd0;
          req_addr = 32'hFFF0; req_rnw = ~rnw;
        end
        @(negedge clk);
        addr_ack = 1'b0; req_rnw = rnw;
      end
      pat = {32'hF0F0_0000 + 32'(i), 32'h5A00_0000 + 32'(i * 3)};
      data_ack = 1'b1; rd_lanes = pat;
      if (rnw) begin
        off = int'(base + AW'(i * sb)) % (MW / 8);
        model_buf = (model_buf & ~(mask << (8 * off))) | ((pat & mask) << (8 * off));
      end
      @(negedge clk);
      data_ack = 1'b0;
    end
    chk(done == 1'b1, "R9", "done after last beat", 128'(done), 1);
    chk(busy == 1'b0, "R9", "busy cleared", 128'(busy), 0);
    chk(popped == n && exp_q.size() == 0, req, "beat count", 128'(popped), 128'(n));
    chk(rd_buf == model_buf, "R8", "read buffer", 128'(rd_buf), 128'(model_buf));
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", 128'(done), 0);
    exp_q.delete();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy", 128'(busy), 0);
    chk(done == 0, "R1", "done", 128'(done), 0);
    chk(conv_active == 0, "R1", "conv_active", 128'(conv_active), 0);
    chk(rd_buf == 0, "R1", "rd_buf", 128'(rd_buf), 0);

    // R3: single transfers to a 32-bit slave, two beats each
    xfer(1'b0, 32'h104, 4'd0, 2'b00, 0, 0, 64'h8877_6655_4433_2211, "R3");
    xfer(1'b1, 32'h10C, 4'd0, 2'b00, 1, 0, '0, "R3");
    // R2: equal and wider slave codes give one beat
    xfer(1'b0, 32'h020, 4'd0, 2'b01, 0, 0, 64'hCAFE_F00D_1234_5678, "R2");
    xfer(1'b1, 32'h028, 4'd0, 2'b10, 0, 0, '0, "R2");
    xfer(1'b1, 32'h030, 4'd0, 2'b11, 2, 0, '0, "R2");
    // R4: line transfers
    xfer(1'b0, 32'h238, 4'd1, 2'b00, 1, 0, 64'h0102_0304_0506_0708, "R4");
    xfer(1'b1, 32'h358, 4'd2, 2'b01, 0, 0, '0, "R4");
    xfer(1'b0, 32'h010, 4'd3, 2'b01, 0, 0, 64'hDEAD_BEEF_ABCD_0123, "R4");
    xfer(1'b1, 32'h018, 4'd1, 2'b01, 0, 0, '0, "R4");
    // R10: addr_ack during a long read is ignored
    xfer(1'b1, 32'h47C, 4'd3, 2'b00, 2, 1, '0, "R10");
    // R5: unknown size codes behave as single
    xfer(1'b0, 32'h054, 4'd5, 2'b00, 0, 0, 64'h1357_9BDF_2468_ACE0, "R5");
    xfer(1'b1, 32'h060, 4'd9, 2'b00, 0, 0, '0, "R5");

    // R10: data_ack while idle changes nothing
    @(negedge clk);
    data_ack = 1'b1; rd_lanes = '1;
    @(negedge clk);
    data_ack = 1'b0;
    chk(busy == 0, "R10", "idle ack busy", 128'(busy), 0);
    chk(done == 0, "R10", "idle ack done", 128'(done), 0);
    chk(rd_buf == model_buf, "R10", "idle ack rd_buf", 128'(rd_buf), 128'(model_buf));
    repeat (2) @(negedge clk);
    summary();
  end
endmodule